// File: doc/BRIEF.md
# Three-Channel Programmable Interval Counter

This block provides three independent 16-bit down-counters behind a small 8-bit register port. Software first writes a control word to a shared control address. The word names a channel and sets how that channel's count is moved over the byte-wide bus: low byte only, high byte only, or low byte then high byte. The same word sets a counting mode and chooses binary or BCD counting. Software then writes the starting count to the channel's own data address.

A channel counts down once for each cycle in which its enable bit is high. Each channel's output can serve as an interrupt request. In terminal-count mode the output rises once when the count runs out. In rate mode the output gives a periodic one-period low pulse and the count reloads itself.

Reads of a data address return the live count, one byte per read, in the channel's byte order. A latch command freezes a snapshot so that software can read a stable two-byte value while counting goes on.

Top module: `prog_interval_counter`

## Requirements
- R1: After synchronous reset, rdata and every irq_out bit are 0, each channel reads its count as 0 in low-byte-only order, and enable pulses change nothing until a count has been loaded.
- R2: A write to address 3 is a control word. Bits [7:6] select the channel, and code 3 is ignored with no effect on any channel. Bits [5:4] select access: 00 = latch command, 01 = low byte only, 10 = high byte only, 11 = low then high. Bits [3:1] are the mode, and bit 0 = 1 selects BCD.
- R3: In low-only or high-only access, one data write loads the count at once, and the byte that was not written becomes zero.
- R4: In low-then-high access, the first data write stores the low byte and the second write loads the full count. Any control word to the channel returns its write and read byte pointers to the low byte.
- R5: A read strobe on data address 0–2 presents the selected byte on rdata in the next cycle, and rdata holds its value otherwise. In low-then-high access, successive reads return the low byte and then the high byte, alternating.
- R6: A latch command copies the live count into a snapshot without stopping the count. Reads return the snapshot, in the channel's byte order, until it has been read completely, and then return the live count again. A latch command that arrives while a snapshot is still unread is ignored.
- R7: In binary counting, each enable subtracts 1 modulo 65536, so a loaded 0 acts as 65536.
- R8: In BCD counting, each enable subtracts 1 from a four-digit decimal value, and each digit wraps from 0 to 9. A loaded 0 acts as 10000.
- R9: In mode 0, and in every mode code except 2, the output goes low on the control word and on each load. It rises when the count steps from 1 to 0, and it then stays high until the next control word or load.
- R10: In mode 2, the output is high after the control word and after a load. It goes low for exactly one enable period when the count reaches 1, and on the next enable the count reloads and the output returns high. The period is N enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for addr/wdata |
| rd_en | input | 1 | Read strobe for addr |
| addr | input | 2 | 0–2 channel data, 3 control word |
| wdata | input | 8 | Write data byte |
| cnt_en | input | NCH | Per-channel count enable |
| rdata | output | 8 | Registered read byte |
| irq_out | output | NCH | Registered channel outputs |

## Verification
The embedded properties check several things on every cycle. A terminal-count output never falls without a control word or load, and a rate-mode low pulse never outlasts one enable. A held snapshot never changes while it is pending, and an idle channel never moves. Control words with the reserved selector reach no channel, and rdata holds between read strobes. Only the bench scenarios can show the actual count values: BCD digit wrap, the zero-as-maximum loads, byte ordering and pointer reset, snapshot contents against the live value, and the exact pulse period.

// File: rtl/tc_pkg.sv
package tc_pkg;
  localparam int BYTE_W  = 8;
  localparam int COUNT_W = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'b00,
    ACC_LO    = 2'b01,
    ACC_HI    = 2'b10,
    ACC_LH    = 2'b11
  } acc_e;

  // four-digit decimal decrement with digit-wise borrow
  function automatic logic [COUNT_W-1:0] bcd_dec(input logic [COUNT_W-1:0] v);
    logic [COUNT_W-1:0] r;
    logic               borrow;
    r      = v;
    borrow = 1'b1;
    for (int d = 0; d < COUNT_W / 4; d++) begin
      if (borrow) begin
        if (v[d*4 +: 4] == 4'd0) begin
          r[d*4 +: 4] = 4'd9;
        end else begin
          r[d*4 +: 4] = v[d*4 +: 4] - 4'd1;
          borrow      = 1'b0;
        end
      end
    end
    return r;
  endfunction
endpackage

// File: rtl/tc_cw_decode.sv
module tc_cw_decode
  import tc_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NCH-1:0]    cfg_we,
  output logic [NCH-1:0]    latch_req,
  output logic [NCH-1:0]    data_we
);
  localparam logic [1:0] CTRL_ADDR = 2'd3;

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (addr == CTRL_ADDR);

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic sel_hit;
    assign sel_hit      = ctrl_wr && (wdata[7:6] == 2'(i));
    assign data_we[i]   = wr_en && (addr == 2'(i));
    assign cfg_we[i]    = sel_hit && (wdata[5:4] != ACC_LATCH);
    assign latch_req[i] = sel_hit && (wdata[5:4] == ACC_LATCH);
  end

  AST_RESERVED_SEL_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (ctrl_wr && wdata[7:6] == 2'd3) |-> (cfg_we == '0 && latch_req == '0)); // R2

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_we, latch_req, data_we})); // R2
endmodule

// File: rtl/tc_channel.sv
module tc_channel
  import tc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              latch_req,
  input  logic              data_we,
  input  logic              rd_stb,
  input  logic              cnt_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              tc_out
);
  localparam logic [2:0] MODE_RATE = 3'd2;

  acc_e               acc_q;
  logic [2:0]         mode_q;
  logic               bcd_q;
  logic [COUNT_W-1:0] count_q, reload_q, hold_q;
  logic               latched_q, wr_hi_q, rd_hi_q, armed_q, out_q;

  logic               rate_mode;
  logic [COUNT_W-1:0] dec_val, load_val, rd_src;
  logic               load_now;

  assign rate_mode = (mode_q == MODE_RATE);
  assign dec_val   = bcd_q ? bcd_dec(count_q) : count_q - 1'b1;

  always_comb begin
    load_val = {wdata, reload_q[BYTE_W-1:0]};
    load_now = data_we && wr_hi_q;
    case (acc_q)
      ACC_LO: begin
        load_val = {{BYTE_W{1'b0}}, wdata};
        load_now = data_we;
      end
      ACC_HI: begin
        load_val = {wdata, {BYTE_W{1'b0}}};
        load_now = data_we;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= ACC_LO;
      mode_q    <= '0;
      bcd_q     <= 1'b0;
      count_q   <= '0;
      reload_q  <= '0;
      hold_q    <= '0;
      latched_q <= 1'b0;
      wr_hi_q   <= 1'b0;
      rd_hi_q   <= 1'b0;
      armed_q   <= 1'b0;
      out_q     <= 1'b0;
    end else begin
      if (cfg_we) begin
        acc_q     <= acc_e'(wdata[5:4]);
        mode_q    <= wdata[3:1];
        bcd_q     <= wdata[0];
        wr_hi_q   <= 1'b0;
        rd_hi_q   <= 1'b0;
        latched_q <= 1'b0;
        armed_q   <= 1'b0;
        out_q     <= (wdata[3:1] == MODE_RATE);
      end else if (data_we) begin
        if (load_now) begin
          reload_q <= load_val;
          count_q  <= load_val;
          armed_q  <= 1'b1;
          out_q    <= rate_mode;
          wr_hi_q  <= 1'b0;
        end else begin
          reload_q[BYTE_W-1:0] <= wdata;
          wr_hi_q              <= 1'b1;
        end
      end else if (armed_q && cnt_en) begin
        if (rate_mode && count_q == 1) begin
          count_q <= reload_q;
          out_q   <= 1'b1;
        end else begin
          count_q <= dec_val;
          if (rate_mode)         out_q <= (dec_val != 1);
          else if (count_q == 1) out_q <= 1'b1;
        end
      end

      if (latch_req && !latched_q) begin
        hold_q    <= count_q;
        latched_q <= 1'b1;
      end

      if (rd_stb) begin
        if (acc_q == ACC_LH) rd_hi_q <= !rd_hi_q;
        if (latched_q && (acc_q != ACC_LH || rd_hi_q)) latched_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rd_src = latched_q ? hold_q : count_q;
    case (acc_q)
      ACC_HI:  rd_byte = rd_src[COUNT_W-1:BYTE_W];
      ACC_LH:  rd_byte = rd_hi_q ? rd_src[COUNT_W-1:BYTE_W] : rd_src[BYTE_W-1:0];
      default: rd_byte = rd_src[BYTE_W-1:0];
    endcase
  end

  assign tc_out = out_q;

  AST_TC_STAYS_HIGH: assert property (@(posedge clk) disable iff (rst)
    (!rate_mode && out_q && !cfg_we && !load_now) |=> out_q); // R9

  AST_LOAD_DROPS_TC: assert property (@(posedge clk) disable iff (rst)
    (!rate_mode && load_now && !cfg_we) |=> !out_q); // R9

  AST_RATE_PULSE_ONE: assert property (@(posedge clk) disable iff (rst)
    (rate_mode && armed_q && !out_q && cnt_en && !cfg_we && !data_we) |=> out_q); // R10

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (latched_q && !cfg_we) |=> $stable(hold_q)); // R6

  AST_IDLE_NO_COUNT: assert property (@(posedge clk) disable iff (rst)
    (!armed_q && !data_we && !cfg_we) |=> $stable(count_q)); // R1
endmodule

// File: rtl/prog_interval_counter.sv
module prog_interval_counter
  import tc_pkg::*;
#(
  parameter int NCH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [NCH-1:0]    cnt_en,
  output logic [BYTE_W-1:0] rdata,
  output logic [NCH-1:0]    irq_out
);
  logic [NCH-1:0]    cfg_we, latch_req, data_we;
  logic [BYTE_W-1:0] ch_byte [NCH];
  logic [BYTE_W-1:0] rd_sel;
  logic              rd_hit;

  tc_cw_decode #(.NCH(NCH)) dec_i (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .cfg_we    (cfg_we),
    .latch_req (latch_req),
    .data_we   (data_we)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tc_channel ch_i (
      .clk       (clk),
      .rst       (rst),
      .cfg_we    (cfg_we[i]),
      .latch_req (latch_req[i]),
      .data_we   (data_we[i]),
      .rd_stb    (rd_en && (addr == 2'(i))),
      .cnt_en    (cnt_en[i]),
      .wdata     (wdata),
      .rd_byte   (ch_byte[i]),
      .tc_out    (irq_out[i])
    );
  end

  always_comb begin
    rd_sel = '0;
    rd_hit = 1'b0;
    for (int i = 0; i < NCH; i++) begin
      if (addr == 2'(i)) begin
        rd_sel = ch_byte[i];
        rd_hit = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  rdata <= '0;
    else if (rd_en && rd_hit) rdata <= rd_sel;
  end

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata)); // R5
endmodule

// File: tb/prog_interval_counter_tb.sv
`timescale 1ns/1ps
module prog_interval_counter_tb_top;
  localparam int NCH = 3;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_TK = 2'd2, K_IRQ = 2'd3;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]       addr = '0;
  logic [7:0]       wdata = '0;
  logic [NCH-1:0]   cnt_en = '0;
  logic [7:0]       rdata;
  logic [NCH-1:0]   irq_out;
  int               n_chk = 0, n_err = 0;
  logic [23:0]      v;
  logic [7:0]       rv;

  always #2.5 clk = ~clk;

  prog_interval_counter #(.NCH(NCH)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .cnt_en(cnt_en), .rdata(rdata), .irq_out(irq_out)
  );

  // {kind[2], addr[2], data[8], expect[8], requirement[4]}
  localparam int NV = 44;
  localparam logic [23:0] VEC [NV] = '{
    {K_WR, 2'd3, 8'h30, 8'h00, 4'd2},  // ch0: low-then-high, mode 0, binary (R2)
    {K_IRQ,2'd0, 8'h00, 8'h00, 4'd9},  // R9 low after control word
    {K_WR, 2'd0, 8'h03, 8'h00, 4'd4},
    {K_WR, 2'd0, 8'h00, 8'h00, 4'd4},  // R4 count = 3
    {K_RD, 2'd0, 8'h00, 8'h03, 4'd5},  // R5 low byte
    {K_RD, 2'd0, 8'h00, 8'h00, 4'd5},  // R5 high byte
    {K_TK, 2'd0, 8'h01, 8'h00, 4'd7},
    {K_TK, 2'd0, 8'h01, 8'h00, 4'd7},
    {K_IRQ,2'd0, 8'h00, 8'h00, 4'd9},  // count 1, still low
    {K_TK, 2'd0, 8'h01, 8'h00, 4'd9},
    {K_IRQ,2'd0, 8'h00, 8'h01, 4'd9},  // R9 rise at 1->0
    {K_TK, 2'd0, 8'h01, 8'h00, 4'd7},
    {K_RD, 2'd0, 8'h00, 8'hFF, 4'd7},  // R7 wrap to FFFF
    {K_RD, 2'd0, 8'h00, 8'hFF, 4'd7},
    {K_IRQ,2'd0, 8'h00, 8'h01, 4'd9},  // stays high
    {K_WR, 2'd3, 8'h54, 8'h00, 4'd10}, // ch1: low only, mode 2
    {K_IRQ,2'd0, 8'h00, 8'h03, 4'd10}, // R10 high after control word
    {K_WR, 2'd1, 8'h03, 8'h00, 4'd3},  // R3 low-only load of 3
    {K_TK, 2'd0, 8'h02, 8'h00, 4'd10},
    {K_IRQ,2'd0, 8'h00, 8'h03, 4'd10}, // count 2
    {K_TK, 2'd0, 8'h02, 8'h00, 4'd10},
    {K_IRQ,2'd0, 8'h00, 8'h01, 4'd10}, // count 1: low
    {K_TK, 2'd0, 8'h02, 8'h00, 4'd10},
    {K_IRQ,2'd0, 8'h00, 8'h03, 4'd10}, // reloaded, high
    {K_RD, 2'd1, 8'h00, 8'h03, 4'd10}, // reload value back
    {K_WR, 2'd3, 8'hB1, 8'h00, 4'd2},  // ch2: low-then-high, BCD
    {K_IRQ,2'd0, 8'h00, 8'h03, 4'd9},
    {K_WR, 2'd2, 8'h00, 8'h00, 4'd4},
    {K_WR, 2'd2, 8'h10, 8'h00, 4'd4},  // 1000 decimal
    {K_TK, 2'd0, 8'h04, 8'h00, 4'd8},
    {K_RD, 2'd2, 8'h00, 8'h99, 4'd8},  // R8 0999
    {K_RD, 2'd2, 8'h00, 8'h09, 4'd8},
    {K_WR, 2'd3, 8'h80, 8'h00, 4'd6},  // R6 latch ch2
    {K_TK, 2'd0, 8'h04, 8'h00, 4'd6},  // live 0998
    {K_RD, 2'd2, 8'h00, 8'h99, 4'd6},
    {K_RD, 2'd2, 8'h00, 8'h09, 4'd6},
    {K_RD, 2'd2, 8'h00, 8'h98, 4'd6},  // live after snapshot read
    {K_RD, 2'd2, 8'h00, 8'h09, 4'd6},
    {K_WR, 2'd3, 8'hF0, 8'h00, 4'd2},  // R2 reserved selector
    {K_RD, 2'd2, 8'h00, 8'h98, 4'd2},
    {K_RD, 2'd2, 8'h00, 8'h09, 4'd2},
    {K_IRQ,2'd0, 8'h00, 8'h03, 4'd2},
    {K_RD, 2'd0, 8'h00, 8'hFF, 4'd2},
    {K_RD, 2'd1, 8'h00, 8'h03, 4'd2}
  };

  task automatic chk(input string what, input int req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic do_tk(input logic [NCH-1:0] m);
    @(negedge clk); cnt_en = m;
    @(negedge clk); cnt_en = '0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 reset irq", 1, {5'b0, irq_out}, 8'h00);
    chk("R1 reset rdata", 1, rdata, 8'h00);

    for (int k = 0; k < NV; k++) begin
      v = VEC[k];
      case (v[23:22])
        K_WR:  do_wr(v[21:20], v[19:12]);
        K_RD:  begin do_rd(v[21:20], rv); chk("table read", int'(v[3:0]), rv, v[11:4]); end
        K_TK:  do_tk(v[14:12]);
        default: chk("table irq", int'(v[3:0]), {5'b0, irq_out}, v[11:4]);
      endcase
    end

    // R1: reset again, idle channels ignore enables
    do_reset();
    chk("R1 irq after reset", 1, {5'b0, irq_out}, 8'h00);
    do_tk(3'b111);
    chk("R1 idle irq", 1, {5'b0, irq_out}, 8'h00);
    do_rd(2'd0, rv);
    chk("R1 idle count", 1, rv, 8'h00);

    // R7: binary zero acts as 65536
    do_wr(2'd3, 8'h10);
    do_wr(2'd0, 8'h00);
    do_tk(3'b001);
    do_rd(2'd0, rv);
    chk("R7 zero load binary", 7, rv, 8'hFF);
    chk("R9 no early terminal", 9, {5'b0, irq_out}, 8'h00);

    // R8: BCD zero acts as 10000
    do_wr(2'd3, 8'h51);
    do_wr(2'd1, 8'h00);
    do_tk(3'b010);
    do_rd(2'd1, rv);
    chk("R8 zero load bcd", 8, rv, 8'h99);

    // R6: second latch while pending is ignored
    do_wr(2'd3, 8'h40);
    do_tk(3'b010);
    do_wr(2'd3, 8'h40);
    do_tk(3'b010);
    do_rd(2'd1, rv);
    chk("R6 first snapshot kept", 6, rv, 8'h99);
    do_rd(2'd1, rv);
    chk("R6 live after snapshot", 6, rv, 8'h97);

    // R4: control word resets the byte pointer
    do_wr(2'd3, 8'h30);
    do_wr(2'd0, 8'h05);
    do_wr(2'd3, 8'h30);
    do_wr(2'd0, 8'h02);
    do_wr(2'd0, 8'h00);
    do_tk(3'b001);
    chk("R4 count 1 low", 4, {7'b0, irq_out[0]}, 8'h00);
    do_tk(3'b001);
    chk("R4 pointer reset terminal", 4, {7'b0, irq_out[0]}, 8'h01);

    // R3: high-only load zeroes the low byte
    do_wr(2'd3, 8'hA0);
    do_wr(2'd2, 8'h01);
    do_tk(3'b100);
    do_wr(2'd3, 8'h80);
    do_rd(2'd2, rv);
    chk("R3 high-only load", 3, rv, 8'h00);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule